// File: doc/BRIEF.md
# Eight-Channel Stereo Volume Mixer

The mixer takes eight signed sample streams, one per voice channel. Each stream has its own valid strobe at the sample rate, and the mixer combines the streams into a stereo pair of 14-bit unsigned DAC codes.

Each channel sample is scaled in three layers:

- a per-channel volume step;
- a separate left and right pan step;
- a global power-of-two scale, applied to each side's sum.

The per-channel and pan steps use a 2 dB-per-code gain table of 9-bit fractions, where 256 means unity. Every scaling step truncates toward zero. The scaled left and right sums are offset to mid-scale and clamped into the DAC code range. The DAC codes are registered once per output-sample tick and held in between, so the DAC sees a step waveform.

Settings arrive through a simple write port. The port carries a register selector, a channel index and one data byte. A channel that is not active contributes the zero level, which reads as mid-scale at the output when it is the only contributor.

Top module: `stereo_vol_mixer`

## Requirements
- R1: While and after reset, `dac_l` and `dac_r` read 8192 and `dac_valid` is low. Every channel volume, every pan nibble and the global scale reset to code 0, which means 0 dB and full amplitude.
- R2: A write with `cfg_sel`=0 sets channel `cfg_ch` volume to `cfg_data[3:0]`. Code k scales the held sample by G[k]/256, truncated toward zero. G[k] is round(256·10^(-k/10)): 256,203,162,128,102,81,64,51,41,32,26,20,16,13,10,8.
- R3: A write with `cfg_sel`=1 sets channel `cfg_ch` pan. `cfg_data[3:0]` is the left code and `cfg_data[7:4]` is the right code, both on the R2 table. Each side applies its pan gain, truncated toward zero, after the volume gain.
- R4: A write with `cfg_sel`=2 sets the global code from `cfg_data[1:0]`. Codes 0,1,2,3 divide each side's channel sum by 1,2,4,8, truncated toward zero.
- R5: Each output is the scaled sum plus 8192, clamped to 0..16383. It never wraps.
- R6: A channel whose `ch_active` bit is low contributes zero to both sums. With all channels inactive, both outputs read 8192.
- R7: The outputs change only on the clock edge where `out_tick` is high, and they reflect the state before that edge. `dac_valid` is high for exactly the cycle after each tick.
- R8: A channel's held sample updates only on an edge where its `smp_valid` bit is high. Its sample is `smp_data[14i+13:14i]`, a signed 14-bit value.
- R9: A write with `cfg_sel`=3 changes nothing. A write to one channel leaves the other channels' settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 2 | 0 volume, 1 pan, 2 global, 3 reserved |
| cfg_ch | input | 3 | Channel index for volume and pan writes |
| cfg_data | input | 8 | Settings byte |
| smp_valid | input | 8 | Per-channel sample strobe |
| smp_data | input | 112 | Eight signed 14-bit samples, channel 0 in the low bits |
| ch_active | input | 8 | Per-channel active flag |
| out_tick | input | 1 | Output-sample update strobe |
| dac_l | output | 14 | Left DAC code |
| dac_r | output | 14 | Right DAC code |
| dac_valid | output | 1 | Pulses the cycle after an update |

## Verification
The bench drives all eight channels at full positive and full negative scale, so the sums run past both ends of the code range. A mixer that wraps instead of clamping would give a code near the opposite rail. The vectors mix odd negative samples with uneven left and right pan codes. A design that floors negative products, or swaps the pan nibbles, is off by one or reports the wrong side. Further tests cover:

- a sample changed without its strobe;
- a reserved-selector write;
- a write to another channel;
- a load with no tick;
- a mute of every channel.

Each of these must leave the output untouched or return it to mid-scale.

// File: rtl/mixer_pkg.sv
// Shared types and the 2 dB gain table for the stereo volume mixer.
// Assumes gains are unsigned fractions where 256 equals unity.
package mixer_pkg;

    localparam int GAIN_W    = 9;
    localparam int GAIN_FRAC = 8;

    typedef enum logic [1:0] {
        SEL_VOL = 2'd0,
        SEL_PAN = 2'd1,
        SEL_GLB = 2'd2,
        SEL_RSV = 2'd3
    } cfg_sel_e;

    // Attenuation code to 9-bit fractional gain, 2 dB per step
    function automatic logic [GAIN_W-1:0] step_gain(input logic [3:0] code);
        case (code)
            4'd0:  step_gain = 9'd256;
            4'd1:  step_gain = 9'd203;
            4'd2:  step_gain = 9'd162;
            4'd3:  step_gain = 9'd128;
            4'd4:  step_gain = 9'd102;
            4'd5:  step_gain = 9'd81;
            4'd6:  step_gain = 9'd64;
            4'd7:  step_gain = 9'd51;
            4'd8:  step_gain = 9'd41;
            4'd9:  step_gain = 9'd32;
            4'd10: step_gain = 9'd26;
            4'd11: step_gain = 9'd20;
            4'd12: step_gain = 9'd16;
            4'd13: step_gain = 9'd13;
            4'd14: step_gain = 9'd10;
            default: step_gain = 9'd8;
        endcase
    endfunction

endpackage

// File: rtl/mix_cfg_regs.sv
// Settings registers: per-channel volume, per-channel left/right pan and
// the global scale code. Assumes one write per strobe; reserved selector
// writes are dropped.
module mix_cfg_regs
    import mixer_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [7:0]     cfg_data,
    output logic [3:0]     vol_q   [NCH],
    output logic [3:0]     pan_l_q [NCH],
    output logic [3:0]     pan_r_q [NCH],
    output logic [1:0]     glb_q
);

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chreg
            // Per-channel volume and pan update on an addressed write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vol_q[gi]   <= 4'd0;
                    pan_l_q[gi] <= 4'd0;
                    pan_r_q[gi] <= 4'd0;
                end else if (cfg_we && cfg_ch == CHW'(gi)) begin
                    if (sel == SEL_VOL) begin
                        vol_q[gi] <= cfg_data[3:0];
                    end
                    if (sel == SEL_PAN) begin
                        pan_l_q[gi] <= cfg_data[3:0];
                        pan_r_q[gi] <= cfg_data[7:4];
                    end
                end
            end
        end
    endgenerate

    // Global scale code update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q <= 2'd0;
        end else if (cfg_we && sel == SEL_GLB) begin
            glb_q <= cfg_data[1:0];
        end
    end

endmodule

// File: rtl/mix_chan_gain.sv
// One channel: holds the latest strobed sample and produces its left and
// right contributions after volume and pan gains. Assumes attenuation only
// (gain <= 1), so results fit the sample width.
module mix_chan_gain
    import mixer_pkg::*;
#(
    parameter int SW = 14,
    localparam int PW = SW + GAIN_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] smp_data,
    input  logic                 active,
    input  logic [3:0]           vol,
    input  logic [3:0]           pan_l,
    input  logic [3:0]           pan_r,
    output logic signed [SW-1:0] con_l,
    output logic signed [SW-1:0] con_r
);

    logic signed [SW-1:0] held_q;
    logic signed [SW-1:0] src;
    logic signed [SW-1:0] after_vol;

    // Scale a sample by a fractional gain, truncating toward zero
    function automatic logic signed [SW-1:0] atten(
        input logic signed [SW-1:0] x,
        input logic [GAIN_W-1:0]    g
    );
        logic signed [PW-1:0] xe;
        logic signed [PW-1:0] ge;
        logic signed [PW-1:0] p;
        logic signed [PW-1:0] mag;
        xe  = PW'(x);
        ge  = PW'($signed({1'b0, g}));
        p   = xe * ge;
        mag = (p < 0) ? -p : p;
        mag = mag >>> GAIN_FRAC;
        atten = (p < 0) ? -mag[SW-1:0] : mag[SW-1:0];
    endfunction

    // Capture the sample only on its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (smp_valid) begin
            held_q <= smp_data;
        end
    end

    // Apply volume, then independent left and right pan gains
    always_comb begin
        src       = active ? held_q : '0;
        after_vol = atten(src, step_gain(vol));
        con_l     = atten(after_vol, step_gain(pan_l));
        con_r     = atten(after_vol, step_gain(pan_r));
    end

endmodule

// File: rtl/mix_sum_sat.sv
// Sums channel contributions per side, applies the global power-of-two
// scale (toward zero), offsets to mid-scale and clamps into the DAC range.
// Outputs register on the output tick and hold otherwise.
module mix_sum_sat #(
    parameter int NCH = 8,
    parameter int SW  = 14,
    parameter int AW  = 20,
    parameter int OW  = 14,
    localparam int MID  = 1 << (OW - 1),
    localparam int FULL = (1 << OW) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 out_tick,
    input  logic [1:0]           glb,
    input  logic signed [SW-1:0] con_l [NCH],
    input  logic signed [SW-1:0] con_r [NCH],
    output logic signed [AW-1:0] sum_l,
    output logic signed [AW-1:0] sum_r,
    output logic [OW-1:0]        dac_l,
    output logic [OW-1:0]        dac_r,
    output logic                 dac_valid
);

    logic [OW-1:0] code_l;
    logic [OW-1:0] code_r;

    // Add one side's contributions and apply the global scale
    function automatic logic signed [AW-1:0] side_sum(
        input logic signed [SW-1:0] c [NCH],
        input logic [1:0]           g
    );
        logic signed [AW-1:0] acc;
        logic signed [AW-1:0] mag;
        acc = '0;
        for (int i = 0; i < NCH; i++) begin
            acc = acc + AW'(c[i]);
        end
        mag = (acc < 0) ? -acc : acc;
        mag = mag >>> g;
        side_sum = (acc < 0) ? -mag : mag;
    endfunction

    // Offset to mid-scale and clamp into the code range
    function automatic logic [OW-1:0] to_code(input logic signed [AW-1:0] s);
        logic signed [AW-1:0] b;
        b = s + AW'(MID);
        if (b < 0) begin
            to_code = '0;
        end else if (b > AW'(FULL)) begin
            to_code = OW'(FULL);
        end else begin
            to_code = b[OW-1:0];
        end
    endfunction

    // Combinational mix of both sides
    always_comb begin
        sum_l  = side_sum(con_l, glb);
        sum_r  = side_sum(con_r, glb);
        code_l = to_code(sum_l);
        code_r = to_code(sum_r);
    end

    // Output register: update on tick, hold between ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_l     <= OW'(MID);
            dac_r     <= OW'(MID);
            dac_valid <= 1'b0;
        end else begin
            dac_valid <= out_tick;
            if (out_tick) begin
                dac_l <= code_l;
                dac_r <= code_r;
            end
        end
    end

endmodule

// File: rtl/stereo_vol_mixer.sv
// Top: eight-channel stereo mixer with layered volume, pan and global
// scaling feeding a pair of clamped 14-bit DAC codes.
module stereo_vol_mixer #(
    parameter int NCH = 8,
    parameter int SW  = 14,
    parameter int AW  = 20,
    parameter int OW  = 14,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [7:0]        cfg_data,
    input  logic [NCH-1:0]    smp_valid,
    input  logic [NCH*SW-1:0] smp_data,
    input  logic [NCH-1:0]    ch_active,
    input  logic              out_tick,
    output logic [OW-1:0]     dac_l,
    output logic [OW-1:0]     dac_r,
    output logic              dac_valid
);

    logic [3:0]           vol_q   [NCH];
    logic [3:0]           pan_l_q [NCH];
    logic [3:0]           pan_r_q [NCH];
    logic [1:0]           glb_q;
    logic signed [SW-1:0] con_l   [NCH];
    logic signed [SW-1:0] con_r   [NCH];
    logic signed [AW-1:0] mix_sum_l;
    logic signed [AW-1:0] mix_sum_r;

    mix_cfg_regs #(.NCH(NCH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .cfg_ch  (cfg_ch),
        .cfg_data(cfg_data),
        .vol_q   (vol_q),
        .pan_l_q (pan_l_q),
        .pan_r_q (pan_r_q),
        .glb_q   (glb_q)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            mix_chan_gain #(.SW(SW)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .smp_valid(smp_valid[gi]),
                .smp_data ($signed(smp_data[gi*SW +: SW])),
                .active   (ch_active[gi]),
                .vol      (vol_q[gi]),
                .pan_l    (pan_l_q[gi]),
                .pan_r    (pan_r_q[gi]),
                .con_l    (con_l[gi]),
                .con_r    (con_r[gi])
            );
        end
    endgenerate

    mix_sum_sat #(.NCH(NCH), .SW(SW), .AW(AW), .OW(OW)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_tick (out_tick),
        .glb      (glb_q),
        .con_l    (con_l),
        .con_r    (con_r),
        .sum_l    (mix_sum_l),
        .sum_r    (mix_sum_r),
        .dac_l    (dac_l),
        .dac_r    (dac_r),
        .dac_valid(dac_valid)
    );

endmodule

// File: rtl/mix_checker.sv
// Assertion checker for the stereo mixer, attached by bind. It watches the
// output register against the pre-clamp scaled sums from the summing stage.
module mix_checker #(
    parameter int NCH = 8,
    parameter int AW  = 20,
    parameter int OW  = 14,
    localparam int MID  = 1 << (OW - 1),
    localparam int FULL = (1 << OW) - 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 out_tick,
    input logic [NCH-1:0]       ch_active,
    input logic [OW-1:0]        dac_l,
    input logic [OW-1:0]        dac_r,
    input logic                 dac_valid,
    input logic signed [AW-1:0] sum_l,
    input logic signed [AW-1:0] sum_r
);

    p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_l == OW'(MID) && dac_r == OW'(MID) && !dac_valid));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_tick |=> ($stable(dac_l) && $stable(dac_r)));

    p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |=> dac_valid);

    p_novalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_tick |=> !dac_valid);

    p_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tick && ch_active == '0) |=> (dac_l == OW'(MID) && dac_r == OW'(MID)));

    p_clamp_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tick && sum_l > AW'(FULL - MID)) |=> dac_l == OW'(FULL));

    p_clamp_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tick && sum_r < -AW'(MID)) |=> dac_r == '0);

endmodule

bind stereo_vol_mixer mix_checker #(.NCH(NCH), .AW(AW), .OW(OW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_tick (out_tick),
    .ch_active(ch_active),
    .dac_l    (dac_l),
    .dac_r    (dac_r),
    .dac_valid(dac_valid),
    .sum_l    (mix_sum_l),
    .sum_r    (mix_sum_r)
);

// File: tb/sim_stereo_vol_mixer.sv
`timescale 1ns/1ps
module sim_stereo_vol_mixer;

    localparam int NCH = 8;
    localparam int SW  = 14;
    localparam int NV  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [2:0]        cfg_ch = 3'd0;
    logic [7:0]        cfg_data = 8'd0;
    logic [NCH-1:0]    smp_valid = '0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic [NCH-1:0]    ch_active = '0;
    logic              out_tick = 1'b0;
    logic [13:0]       dac_l;
    logic [13:0]       dac_r;
    logic              dac_valid;

    int checks = 0;
    int errors = 0;
    int gtab [16];
    bit done = 1'b0;

    always #10 clk = ~clk;

    stereo_vol_mixer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_ch(cfg_ch), .cfg_data(cfg_data), .smp_valid(smp_valid),
        .smp_data(smp_data), .ch_active(ch_active), .out_tick(out_tick),
        .dac_l(dac_l), .dac_r(dac_r), .dac_valid(dac_valid)
    );

    // {vol[27:24], pan[23:16], glb[15:14], sample[13:0]} for channel 0 alone
    localparam logic [27:0] VEC [NV] = '{
        {4'd0,  8'h00, 2'd0, 14'sd1000},
        {4'd1,  8'h00, 2'd0, 14'sd1000},
        {4'd15, 8'h00, 2'd0, -14'sd8192},
        {4'd3,  8'h50, 2'd0, 14'sd4000},
        {4'd0,  8'h0A, 2'd1, -14'sd3001},
        {4'd7,  8'hF0, 2'd2, 14'sd5555},
        {4'd2,  8'h33, 2'd3, -14'sd7777},
        {4'd0,  8'h00, 2'd0, 14'sd8191},
        {4'd0,  8'h00, 2'd0, -14'sd8192},
        {4'd4,  8'hA5, 2'd1, 14'sd123}
    };

    function automatic int att(int x, int code);
        return (x * gtab[code]) / 256;
    endfunction

    function automatic int code_of(int s);
        int b;
        b = s + 8192;
        if (b < 0) return 0;
        if (b > 16383) return 16383;
        return b;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int sel, int ch, int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_ch = 3'(ch); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load(int ch, int val);
        @(negedge clk);
        smp_data[ch*SW +: SW] = 14'(val);
        smp_valid[ch] = 1'b1;
        @(negedge clk);
        smp_valid[ch] = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        out_tick = 1'b1;
        @(negedge clk);
        out_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int el, er, s, v, p, g;
        for (int k = 0; k < 16; k++) gtab[k] = $rtoi(256.0 * (10.0 ** (-k / 10.0)) + 0.5);

        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 dac_l in reset", int'(dac_l), 8192);
        chk("R1 dac_valid in reset", int'(dac_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        ch_active = 8'h01;
        load(0, 1000);
        tick();
        chk("R1 default gains left", int'(dac_l), 9192);
        chk("R1 default gains right", int'(dac_r), 9192);

        // R2 R3 R4 vector table on channel 0
        for (int i = 0; i < NV; i++) begin
            v = int'(VEC[i][27:24]);
            p = int'(VEC[i][23:16]);
            g = int'(VEC[i][15:14]);
            s = int'($signed(VEC[i][13:0]));
            wr(0, 0, v);
            wr(1, 0, p);
            wr(2, 0, g);
            load(0, s);
            tick();
            el = code_of(att(att(s, v), p & 15) / (1 << g));
            er = code_of(att(att(s, v), p >> 4) / (1 << g));
            chk("R2 R3 R4 vector left", int'(dac_l), el);
            chk("R2 R3 R4 vector right", int'(dac_r), er);
        end
        wr(0, 0, 0); wr(1, 0, 0); wr(2, 0, 0);

        // R5 clamp with all channels at full scale
        for (int c = 0; c < NCH; c++) load(c, 8191);
        ch_active = 8'hFF;
        tick();
        chk("R5 clamp high left", int'(dac_l), 16383);
        chk("R5 clamp high right", int'(dac_r), 16383);
        wr(2, 0, 3);
        tick();
        chk("R4 global 1/8 of full sum", int'(dac_l), 16383);
        wr(2, 0, 2);
        tick();
        chk("R5 clamp at global 1/4", int'(dac_r), 16383);
        wr(2, 0, 0);
        for (int c = 0; c < NCH; c++) load(c, -8192);
        tick();
        chk("R5 clamp low left", int'(dac_l), 0);
        chk("R5 clamp low right", int'(dac_r), 0);
        wr(2, 0, 1);
        for (int c = 0; c < NCH; c++) load(c, -1001);
        tick();
        chk("R4 global 1/2 toward zero", int'(dac_l), code_of((-1001 * 8) / 2));

        // R6 inactive channels give mid-scale
        ch_active = 8'h00;
        tick();
        chk("R6 all muted left", int'(dac_l), 8192);
        chk("R6 all muted right", int'(dac_r), 8192);
        wr(2, 0, 0);

        // R7 hold without tick, valid pulse after tick
        ch_active = 8'h01;
        load(0, 2000);
        tick();
        chk("R7 updated on tick", int'(dac_l), 10192);
        chk("R7 valid after tick", int'(dac_valid), 1);
        @(negedge clk);
        chk("R7 valid one cycle only", int'(dac_valid), 0);
        load(0, 3000);
        chk("R7 held without tick", int'(dac_l), 10192);
        tick();
        chk("R7 new value on tick", int'(dac_r), 11192);

        // R8 sample data without strobe ignored
        @(negedge clk);
        smp_data[0 +: SW] = 14'sd7000;
        tick();
        chk("R8 no strobe no capture", int'(dac_l), 11192);

        // R9 reserved selector and other-channel writes ignored for channel 0
        wr(3, 0, 8'hFF);
        tick();
        chk("R9 reserved write", int'(dac_l), 11192);
        wr(0, 1, 15);
        wr(1, 1, 8'hFF);
        tick();
        chk("R9 other channel write", int'(dac_r), 11192);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule